// File: doc/BRIEF.md
# GPIO Task and Event Channel Unit

This block gives a small number of channels (four or eight) control over pins of a general-purpose I/O port. A channel is switched off, used as an edge watcher, or used as an output owner. As an edge watcher it follows one synchronised pin and raises a sticky flag on a rising edge, a falling edge or on either edge. As an output owner it takes the pin and drives it from single-cycle strobes written by software: an OUT strobe that follows the configured polarity, a SET strobe and a CLR strobe.

A separate port-wide event input sets its own sticky flag. Each flag, the per-channel ones and the port one, has an interrupt enable bit, and one interrupt line gathers all the enabled flags. Software reaches everything through a word-addressed register interface with single-cycle writes and a combinational read port. The unit tells the pad ring which pins it currently drives through a per-pin output-enable vector.

Top module: `gpio_chan_unit`

## Requirements
- R1: After reset every configuration word, event flag, port flag and enable bit reads zero, and pin_oe, pin_out and irq are all low.
- R2: Channel n's configuration word is at word address 0x28+n. Bits 1:0 hold the mode: 01 is event, 10 is task, and 00 or 11 is off. Bits 15:8 hold the pin select. Bits 17:16 hold the polarity: 01 is rising, 10 is falling, 11 is either edge or toggle, and 00 is none. Bit 20 holds the initial level. All other bits read back as 0.
- R3: In event mode the flag of channel n (address 0x18+n, bit 0) sets on the second clock edge after the edge that first samples the new pin level. Only transitions that match the polarity set it.
- R4: A set flag stays set until a write with bit 0 equal to 0 reaches its address. If an event arrives in the same cycle as that clear, the flag stays set.
- R5: A high port_evt_in sets the port flag (address 0x20, bit 0) at the next clock edge. The port flag clears under the same rule as R4.
- R6: A write to 0x21 sets the enable bits that are 1 in the written data, and a write to 0x22 clears them. Bit n belongs to channel n and bit NUM_CH to the port flag. Both addresses read back the current enable mask.
- R7: irq is high exactly while at least one flag is set together with its enable bit.
- R8: A configuration write with task mode drives the selected pin to the initial level from the next cycle and raises its pin_oe bit. Rewriting the word while in task mode forces the pin to the new initial level.
- R9: Writing bit 0 = 1 to address 0x08+n (SET) drives channel n high, and to 0x10+n (CLR) drives it low. Writing bit 0 = 1 to 0x00+n (OUT) drives the pin high for rising polarity, low for falling, inverts it for toggle, and leaves it unchanged for none. These strobes act only in task mode.
- R10: Writing zero to a configuration word releases the pin. After that, the channel ignores task strobes and pin edges.
- R11: A pin select of NUM_PINS or above drives no pin and detects no edges.
- R12: When two task-mode channels select the same pin, the lowest-numbered channel sets its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| pin_in | input | NUM_PINS | Pin levels from the pads, asynchronous |
| port_evt_in | input | 1 | Port-wide event pulse |
| pin_out | output | NUM_PINS | Levels driven on owned pins |
| pin_oe | output | NUM_PINS | Pins currently owned by the unit |
| irq | output | 1 | Interrupt request |

## Verification
Edge detection runs with the three polarities against single clean steps and against a pseudo-random pin stream. This separates rising-only, falling-only and either-edge matching, and it exposes a wrong synchroniser depth through the exact cycle at which the flag sets. The output path runs OUT under each polarity, back-to-back toggles, SET and CLR, and initial-level forcing, which separates the polarity decode from the fixed strobes. Clears are placed in the very cycle an event lands, on both a channel flag and the port flag, to show which one wins. Disabled channels, out-of-range pin selects and two channels sharing one pin show that ignored stimulus leaves pin_oe, pin_out and the flags unchanged.

// File: rtl/gpio_chan_unit.sv
module gpio_chan_unit #(
  parameter int NUM_CH   = 4,
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                port_evt_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  localparam int IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int A_OUT    = 'h00;
  localparam int A_SET    = 'h08;
  localparam int A_CLR    = 'h10;
  localparam int A_IN     = 'h18;
  localparam int A_PORT   = 'h20;
  localparam int A_INTSET = 'h21;
  localparam int A_INTCLR = 'h22;
  localparam int A_CFG    = 'h28;
  localparam logic [31:0] CFG_MASK = 32'h0013_FF03;
  localparam logic [1:0]  M_EVT = 2'b01, M_TASK = 2'b10;

  logic [31:0]                a;
  logic [NUM_PINS-1:0]        s1, s2, s3;
  logic [NUM_CH-1:0][31:0]    cfg_q;
  logic [NUM_CH-1:0]          flag_q, lvl_q, is_task, own;
  logic [NUM_CH-1:0][IDX_W-1:0] pidx;
  logic                       pflag_q;
  logic [NUM_CH:0]            int_en_q;

  assign a = 32'(addr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= pin_in; s2 <= s1; s3 <= s2;
    end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [31:0] cfg_r;
    logic        lvl_r, flag_r;
    logic [1:0]  mode, pol;
    logic [7:0]  psel;
    logic        pin_ok, cur, prev, evt;
    logic        hit_cfg, hit_out, hit_set, hit_clr, hit_in;

    assign mode   = cfg_r[1:0];
    assign psel   = cfg_r[15:8];
    assign pol    = cfg_r[17:16];
    assign pin_ok = 32'(psel) < 32'(NUM_PINS);
    assign pidx[c] = psel[IDX_W-1:0];
    assign cur    = pin_ok & s2[pidx[c]];
    assign prev   = pin_ok & s3[pidx[c]];
    assign evt    = (mode == M_EVT) & ((pol[0] & cur & ~prev) | (pol[1] & ~cur & prev));

    assign hit_cfg = wr_en && a == 32'(A_CFG + c);
    assign hit_in  = wr_en && a == 32'(A_IN + c) && !wdata[0];
    assign hit_out = wr_en && a == 32'(A_OUT + c) && wdata[0];
    assign hit_set = wr_en && a == 32'(A_SET + c) && wdata[0];
    assign hit_clr = wr_en && a == 32'(A_CLR + c) && wdata[0];

    assign is_task[c] = (mode == M_TASK);
    assign own[c]     = is_task[c] & pin_ok;
    assign cfg_q[c]   = cfg_r;
    assign lvl_q[c]   = lvl_r;
    assign flag_q[c]  = flag_r;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       cfg_r <= '0;
      else if (hit_cfg) cfg_r <= wdata & CFG_MASK;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) lvl_r <= 1'b0;
      else if (hit_cfg) lvl_r <= (wdata[1:0] == M_TASK) & wdata[20];
      else if (is_task[c]) begin
        if (hit_set)      lvl_r <= 1'b1;
        else if (hit_clr) lvl_r <= 1'b0;
        else if (hit_out)
          case (pol)
            2'b01:   lvl_r <= 1'b1;
            2'b10:   lvl_r <= 1'b0;
            2'b11:   lvl_r <= ~lvl_r;
            default: lvl_r <= lvl_r;
          endcase
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      flag_r <= 1'b0;
      else if (evt)    flag_r <= 1'b1;
      else if (hit_in) flag_r <= 1'b0;
  end

  always_comb begin
    pin_out = '0;
    pin_oe  = '0;
    for (int c = NUM_CH - 1; c >= 0; c--)
      if (own[c]) begin
        pin_oe[pidx[c]]  = 1'b1;
        pin_out[pidx[c]] = lvl_q[c];
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pflag_q <= 1'b0;
    else if (port_evt_in) pflag_q <= 1'b1;
    else if (wr_en && a == 32'(A_PORT) && !wdata[0]) pflag_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) int_en_q <= '0;
    else if (wr_en && a == 32'(A_INTSET)) int_en_q <= int_en_q | wdata[NUM_CH:0];
    else if (wr_en && a == 32'(A_INTCLR)) int_en_q <= int_en_q & ~wdata[NUM_CH:0];

  assign irq = |({pflag_q, flag_q} & int_en_q);

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (a == 32'(A_CFG + c)) rdata = cfg_q[c];
      if (a == 32'(A_IN + c))  rdata = {31'b0, flag_q[c]};
    end
    if (a == 32'(A_PORT)) rdata = {31'b0, pflag_q};
    if (a == 32'(A_INTSET) || a == 32'(A_INTCLR)) rdata[NUM_CH:0] = int_en_q;
  end
endmodule

// File: rtl/gpio_chan_unit_chk.sv
module gpio_chan_unit_chk #(
  parameter int NUM_CH   = 4,
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [NUM_CH:0]     wbits,
  input logic                port_evt_in,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                irq,
  input logic [NUM_CH-1:0]   flag_q,
  input logic [NUM_CH-1:0]   lvl_q,
  input logic [NUM_CH-1:0]   is_task,
  input logic                pflag_q,
  input logic [NUM_CH:0]     int_en_q
);
  logic [31:0] a;
  assign a = 32'(addr);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q[c] && !(wr_en && a == 32'('h18 + c) && !wbits[0]) |=> flag_q[c]);
    p_set_task_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && a == 32'('h08 + c) && wbits[0] && is_task[c] |=> lvl_q[c]);
    p_clr_task_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && a == 32'('h10 + c) && wbits[0] && is_task[c] |=> !lvl_q[c]);
  end

  p_intset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && a == 32'h21 |=> (int_en_q & $past(wbits)) == $past(wbits));
  p_intclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && a == 32'h22 |=> (int_en_q & $past(wbits)) == '0);
  p_port_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    port_evt_in |=> pflag_q);
  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int_en_q == '0 |-> !irq);
  p_oe_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pin_oe) <= NUM_CH);
endmodule

bind gpio_chan_unit gpio_chan_unit_chk #(
  .NUM_CH(NUM_CH), .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wbits(wdata[NUM_CH:0]),
  .port_evt_in(port_evt_in), .pin_oe(pin_oe), .irq(irq), .flag_q(flag_q),
  .lvl_q(lvl_q), .is_task(is_task), .pflag_q(pflag_q), .int_en_q(int_en_q)
);

// File: tb/gpio_chan_unit_bench.sv
module gpio_chan_unit_bench;
  localparam int NCH = 4;
  localparam int NP  = 32;

  logic clk = 0, rst_n = 0, wr_en = 0, port_evt_in = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [NP-1:0] pin_in = 0, pin_out, pin_oe;
  logic irq;

  gpio_chan_unit #(.NUM_CH(NCH), .NUM_PINS(NP), .ADDR_W(8)) u_gpio_chan_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pin_in(pin_in), .port_evt_in(port_evt_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  int m_cfg [NCH];
  bit m_lvl [NCH];
  bit m_flag [NCH];
  bit m_pflag;
  bit [NCH:0] m_en;
  bit [NP-1:0] ms1, ms2, ms3;
  int ma, mmode, mpsel, mpol;
  bit mev, mcu, mpr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin m_cfg[c] = 0; m_lvl[c] = 0; m_flag[c] = 0; end
      m_pflag = 0; m_en = 0; ms1 = 0; ms2 = 0; ms3 = 0;
    end else begin
      ma = int'(addr);
      for (int c = 0; c < NCH; c++) begin
        mmode = m_cfg[c] & 3; mpsel = (m_cfg[c] >> 8) & 255; mpol = (m_cfg[c] >> 16) & 3;
        mev = 0;
        if (mmode == 1 && mpsel < NP) begin
          mcu = ms2[mpsel]; mpr = ms3[mpsel];
          if ((mpol == 1 && mcu && !mpr) || (mpol == 2 && !mcu && mpr) || (mpol == 3 && mcu != mpr)) mev = 1;
        end
        if (mev) m_flag[c] = 1;
        else if (wr_en && ma == 'h18 + c && !wdata[0]) m_flag[c] = 0;
        if (wr_en && ma == 'h28 + c) begin
          m_cfg[c] = int'(wdata & 32'h0013FF03);
          m_lvl[c] = (wdata[1:0] == 2'b10) ? wdata[20] : 1'b0;
        end else if (mmode == 2 && wr_en && wdata[0]) begin
          if (ma == 'h08 + c) m_lvl[c] = 1;
          else if (ma == 'h10 + c) m_lvl[c] = 0;
          else if (ma == c) begin
            if (mpol == 1) m_lvl[c] = 1;
            else if (mpol == 2) m_lvl[c] = 0;
            else if (mpol == 3) m_lvl[c] = !m_lvl[c];
          end
        end
      end
      if (port_evt_in) m_pflag = 1;
      else if (wr_en && ma == 'h20 && !wdata[0]) m_pflag = 0;
      if (wr_en && ma == 'h21) m_en = m_en | wdata[NCH:0];
      else if (wr_en && ma == 'h22) m_en = m_en & ~wdata[NCH:0];
      ms3 = ms2; ms2 = ms1; ms1 = pin_in;
    end
  end

  function automatic logic [31:0] m_read(int a);
    logic [31:0] r = 0;
    for (int c = 0; c < NCH; c++) begin
      if (a == 'h28 + c) r = m_cfg[c];
      if (a == 'h18 + c) r = {31'b0, m_flag[c]};
    end
    if (a == 'h20) r = {31'b0, m_pflag};
    if (a == 'h21 || a == 'h22) r[NCH:0] = m_en;
    return r;
  endfunction

  always @(negedge clk) if (rst_n && !done) begin
    logic [NP-1:0] eo, ev;
    bit ei;
    eo = 0; ev = 0; ei = m_pflag & m_en[NCH];
    for (int c = NCH - 1; c >= 0; c--)
      if ((m_cfg[c] & 3) == 2 && ((m_cfg[c] >> 8) & 255) < NP) begin
        eo[(m_cfg[c] >> 8) & 255] = 1;
        ev[(m_cfg[c] >> 8) & 255] = m_lvl[c];
      end
    for (int c = 0; c < NCH; c++) ei = ei | (m_flag[c] & m_en[c]);
    checks++;
    if (pin_oe !== eo || pin_out !== ev || irq !== ei) begin
      fails++;
      $display("FAIL %s: oe=%h out=%h irq=%b expected oe=%h out=%h irq=%b",
               cur_req, pin_oe, pin_out, irq, eo, ev, ei);
    end
  end

  function automatic logic [31:0] cfgw(int mode, int pin, int pol, int init);
    return 32'(mode | (pin << 8) | (pol << 16) | (init << 20));
  endfunction

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = 8'(a); wdata = d;
    @(negedge clk); wr_en = 0; addr = 0; wdata = 0;
  endtask

  task automatic rd(int a, string tag);
    logic [31:0] e;
    @(negedge clk); addr = 8'(a); #1;
    e = m_read(a);
    checks++;
    if (rdata !== e) begin
      fails++;
      $display("FAIL %s: read 0x%0h got %h expected %h", tag, a, rdata, e);
    end
    addr = 0;
  endtask

  task automatic setpin(int p, bit v);
    @(negedge clk); pin_in[p] = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    logic [15:0] lf;
    idle(2); rst_n = 1; idle(1);
    // R1: reset state
    cur_req = "R1";
    rd('h28, "R1"); rd('h18, "R1"); rd('h20, "R1"); rd('h21, "R1");

    // R2 / R8: task mode entry and readback
    cur_req = "R8";
    wr('h28, 32'hFFFF_FFFF & cfgw(2, 3, 3, 1) | 32'hFF00_0000);
    rd('h28, "R2"); idle(1);
    wr('h28, cfgw(2, 3, 3, 0)); idle(1);
    wr('h28, cfgw(2, 3, 3, 1)); idle(1);

    // R9: strobes
    cur_req = "R9";
    wr('h00, 1); wr('h00, 1); wr('h00, 1);
    wr('h00, 0);
    wr('h28, cfgw(2, 3, 1, 0)); wr('h00, 1);
    wr('h28, cfgw(2, 3, 2, 1)); wr('h00, 1);
    wr('h28, cfgw(2, 3, 0, 1)); wr('h00, 1);
    wr('h10, 1); wr('h08, 1); wr('h10, 1); wr('h08, 0);

    // R3: event edges
    cur_req = "R3";
    wr('h18, 0);
    wr('h29, cfgw(1, 5, 1, 0));
    setpin(5, 1); idle(4); rd('h19, "R3");
    wr('h19, 0); setpin(5, 0); idle(4); rd('h19, "R3");
    wr('h2A, cfgw(1, 6, 2, 0));
    setpin(6, 1); idle(4); rd('h1A, "R3");
    setpin(6, 0); idle(1); rd('h1A, "R3"); idle(3); rd('h1A, "R3");
    wr('h1A, 0); wr('h2A, cfgw(1, 6, 3, 0));
    setpin(6, 1); idle(4); rd('h1A, "R3");
    wr('h1A, 0); setpin(6, 0); idle(4); rd('h1A, "R3");

    // R4: sticky and coincident clear
    cur_req = "R4";
    idle(5); rd('h1A, "R4");
    wr('h1A, 1); rd('h1A, "R4");
    wr('h1A, 0); rd('h1A, "R4");
    wr('h19, 0);
    setpin(5, 1); @(negedge clk); wr('h19, 0); rd('h19, "R4");

    // R5: port event
    cur_req = "R5";
    @(negedge clk); port_evt_in = 1; @(negedge clk); port_evt_in = 0;
    rd('h20, "R5");
    wr('h20, 0); rd('h20, "R5");
    @(negedge clk); port_evt_in = 1; wr_en = 1; addr = 8'h20; wdata = 0;
    @(negedge clk); port_evt_in = 0; wr_en = 0; addr = 0;
    rd('h20, "R5");

    // R6 / R7: enables and interrupt
    cur_req = "R6";
    wr('h21, 32'h12); rd('h21, "R6"); rd('h22, "R6");
    cur_req = "R7";
    wr('h21, 32'h06); idle(2);
    wr('h22, 32'h10); idle(1);
    wr('h22, 32'h02); idle(1);
    wr('h19, 0); wr('h21, 32'h02);
    setpin(5, 0); idle(2); setpin(5, 1); idle(4);
    rd('h21, "R6");
    lf = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      @(negedge clk); pin_in[6] = lf[0]; pin_in[5] = lf[3];
      if (i % 9 == 0) wr('h1A, 0);
    end
    idle(4); rd('h1A, "R7");

    // R10: release and ignore
    cur_req = "R10";
    wr('h28, 0); rd('h28, "R10");
    wr('h00, 1); wr('h08, 1); idle(1);
    wr('h29, 0); wr('h19, 0);
    setpin(5, 0); idle(3); setpin(5, 1); idle(4); rd('h19, "R10");

    // R11: out of range pin select
    cur_req = "R11";
    wr('h2B, cfgw(2, 40, 3, 1)); wr('h0B, 1); idle(1);
    wr('h2B, cfgw(1, 200, 3, 0)); wr('h1B, 0);
    pin_in = '1; idle(4); pin_in = '0; idle(4); rd('h1B, "R11");
    wr('h2B, cfgw(1, 32, 3, 0));
    pin_in = '1; idle(4); rd('h1B, "R11");

    // R12: shared pin
    cur_req = "R12";
    wr('h29, cfgw(2, 9, 3, 0)); wr('h28, cfgw(2, 9, 3, 1)); idle(1);
    wr('h01, 1); idle(1); wr('h00, 1); idle(1);
    wr('h28, 0); idle(2);

    idle(3);
    summary();
  end
endmodule